// File: doc/BRIEF.md
# Transmit Command Decoder with Address Lock

This block sits between an on-chip bus receiver and the outgoing packet path. Every 32-bit word it takes in comes with the bus address it was written to. The block classifies the first word of each command by its top nibble. It collects four-word transmit configurations and uses them to give the transmit path to a single bus address. After that, only that address may start a packet. Each packet's declared byte length decides how many payload words are forwarded to the transmit FIFO write port.

A configuration either takes the lock or is refused. In both cases a one-word reply request goes back to the sender's bus address, which the configuration itself carries. If the owner stops sending in the middle of a packet, an idle timer fills the rest of the packet with zero words. The downstream packet builder therefore always receives the full declared length. A release command hands the lock back. The owner's destination IP and UDP ports are held on outputs for the packet builder.

Top module: `tx_cmd_lock`

## Requirements
- R1: The command type is `in_word[31:28]` of a command's first word: 0x0 configure, 0x1 data header, 0x2 release. Any other value is dropped, with no FIFO write, no reply and no change of lock.
- R2: A configure is four words from one address: {type, timeout in bits 27:0}, destination IP, {destination port in 31:16, source port in 15:0}, sender address. If the block is unlocked or already locked to the same address, the cycle after the fourth word is accepted shows `rep_valid` with `rep_word` = 0x5800_0000, `rep_dest` = the sender address, and the new IP, ports and timeout.
- R3: A granted configure locks the block to the `in_addr` the configure arrived on, not to the sender address inside it.
- R4: A configure on another address while locked yields `rep_word` = 0x6800_0000 to its sender address. The lock, the IP and the ports stay unchanged.
- R5: A data header from the locked address gives a one-cycle `pkt_start` and sets `pkt_len` to `in_word[27:17]`, one cycle after acceptance. Bits 16:0 are ignored. A length of 0 expects no payload.
- R6: A data header that arrives while unlocked, or on an address other than the lock, is dropped.
- R7: After a header, ceil(len/4) words from the locked address are written to the FIFO in the cycle they are accepted, byte 0 in bits 7:0. In the final word, the bytes beyond the length are forced to zero.
- R8: During a configure body or a packet, words from any other address are held off with `in_ready` low. During a packet, `fifo_full` also lowers `in_ready`.
- R9: The idle timer reloads with the timeout value T on the header and on each payload word. After T+1 consecutive packet cycles with no payload word, `timeout_hit` pulses. The missing words are then written as zeros, `in_ready` stays low until they are done, and the lock is kept.
- R10: A release from the locked address drops `locked` one cycle later and produces no reply. A release from any other address is ignored.
- R11: After reset the block is unlocked, with `in_ready` high and no reply or FIFO write.
- R12: `fifo_wr` is never high while `fifo_full` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming bus word present |
| in_ready | output | 1 | Word accepted this cycle when valid |
| in_word | input | 32 | Incoming bus word |
| in_addr | input | ADDR_W | Bus address the word was written to |
| fifo_full | input | 1 | Transmit FIFO cannot take a word |
| fifo_wr | output | 1 | Transmit FIFO write strobe |
| fifo_data | output | 32 | Payload or zero pad word |
| pkt_start | output | 1 | One-cycle pulse per accepted data header |
| pkt_len | output | 11 | Byte length of the current packet |
| dst_ip | output | 32 | Destination IP of the lock owner |
| dst_port | output | 16 | Destination UDP port |
| src_port | output | 16 | Source UDP port |
| locked | output | 1 | Transmit path owned by one address |
| timeout_hit | output | 1 | One-cycle pulse when padding begins |
| rep_valid | output | 1 | Reply request present for one cycle |
| rep_word | output | 32 | Ack/nack word for the reply |
| rep_dest | output | ADDR_W | Bus address the reply goes to |

## Verification
A wrong lock owner shows up at the next header or configure: the FIFO write count or the ack/nack word differs one cycle after acceptance. A miscounted remaining-word counter changes how many words reach the FIFO and when `in_ready` reopens, within the packet. A mistimed timer moves the `timeout_hit` pulse and the number of zero words, so the bench places its idle gaps on both sides of the T+1 boundary.

// File: rtl/txl_pkg.sv
package txl_pkg;

    localparam int WORD_W = 32;

    localparam logic [3:0] TYPE_CONFIGURE = 4'h0;
    localparam logic [3:0] TYPE_HEADER    = 4'h1;
    localparam logic [3:0] TYPE_RELEASE   = 4'h2;
    localparam logic [3:0] REPLY_ACK      = 4'h5;
    localparam logic [3:0] REPLY_NACK     = 4'h6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CFG  = 2'd1,
        ST_DATA = 2'd2,
        ST_PAD  = 2'd3
    } txl_state_e;

    typedef enum logic [1:0] {
        CMD_CONFIGURE = 2'd0,
        CMD_HEADER    = 2'd1,
        CMD_RELEASE   = 2'd2,
        CMD_UNKNOWN   = 2'd3
    } txl_cmd_e;

    function automatic logic [WORD_W-1:0] reply_word(input logic grant);
        reply_word = {(grant ? REPLY_ACK : REPLY_NACK), 1'b1, 27'd0};
    endfunction

endpackage

// File: rtl/txl_type_decode.sv
module txl_type_decode
    import txl_pkg::*;
(
    input  logic [3:0] type_nib,
    output txl_cmd_e   cmd
);
    always_comb begin
        case (type_nib)
            TYPE_CONFIGURE: cmd = CMD_CONFIGURE;
            TYPE_HEADER:    cmd = CMD_HEADER;
            TYPE_RELEASE:   cmd = CMD_RELEASE;
            default:        cmd = CMD_UNKNOWN;
        endcase
    end
endmodule

// File: rtl/txl_lane_mask.sv
module txl_lane_mask #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0]       word_in,
    input  logic [$clog2(LANES)-1:0] keep_lanes,
    output logic [LANES*8-1:0]       word_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic keep;
        assign keep = (keep_lanes == '0) || (g < int'(keep_lanes));
        assign word_out[g*8 +: 8] = keep ? word_in[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/txl_timer.sv
module txl_timer #(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = load_val;
        end else if (run && (count_q != '0)) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign expired = (count_q == '0);
endmodule

// File: rtl/tx_cmd_lock.sv
module tx_cmd_lock
    import txl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 11,
    parameter int TMO_W  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_word,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [31:0]       fifo_data,
    output logic              pkt_start,
    output logic [LEN_W-1:0]  pkt_len,
    output logic [31:0]       dst_ip,
    output logic [15:0]       dst_port,
    output logic [15:0]       src_port,
    output logic              locked,
    output logic              timeout_hit,
    output logic              rep_valid,
    output logic [31:0]       rep_word,
    output logic [ADDR_W-1:0] rep_dest
);
    localparam int LANES   = WORD_W / 8;
    localparam int LANE_W  = $clog2(LANES);
    localparam int WCNT_W  = LEN_W - LANE_W + 1;
    localparam int LEN_LSB = 17;

    typedef struct packed {
        txl_state_e        state;
        logic [1:0]        cfg_cnt;
        logic [ADDR_W-1:0] cfg_addr;
        logic [TMO_W-1:0]  cfg_tmo;
        logic [31:0]       cfg_ip;
        logic [31:0]       cfg_ports;
        logic              lock_on;
        logic [ADDR_W-1:0] lock_addr;
        logic [TMO_W-1:0]  tmo;
        logic [31:0]       ip;
        logic [31:0]       ports;
        logic [WCNT_W-1:0] rem;
        logic [LANE_W-1:0] tail_lanes;
        logic              start;
        logic [LEN_W-1:0]  len;
        logic              to_hit;
        logic              rep_v;
        logic              rep_ack;
        logic [ADDR_W-1:0] rep_addr;
    } regs_t;

    regs_t r_d, r_q;

    txl_cmd_e          cmd;
    logic              tmr_load, tmr_run, tmr_expired;
    logic [31:0]       masked_word;
    logic              ready_c, accept;
    logic              grant;
    logic [LEN_W-1:0]  hdr_len;
    logic [LEN_W:0]    hdr_len_rnd;
    logic [WCNT_W-1:0] hdr_words;

    txl_type_decode u_decode (
        .type_nib (in_word[31:28]),
        .cmd      (cmd)
    );

    txl_lane_mask #(.LANES(LANES)) u_mask (
        .word_in    (in_word),
        .keep_lanes (r_q.tail_lanes),
        .word_out   (masked_word)
    );

    txl_timer #(.CNT_W(TMO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (r_q.tmo),
        .run      (tmr_run),
        .expired  (tmr_expired)
    );

    assign hdr_len     = in_word[LEN_LSB +: LEN_W];
    assign hdr_len_rnd = {1'b0, hdr_len} + (LEN_W+1)'(LANES - 1);
    assign hdr_words   = WCNT_W'(hdr_len_rnd >> LANE_W);
    assign grant       = !r_q.lock_on || (r_q.lock_addr == r_q.cfg_addr);

    always_comb begin
        case (r_q.state)
            ST_IDLE: ready_c = 1'b1;
            ST_CFG:  ready_c = (in_addr == r_q.cfg_addr);
            ST_DATA: ready_c = (in_addr == r_q.lock_addr) && !fifo_full;
            default: ready_c = 1'b0;
        endcase
    end
    assign accept = in_valid && ready_c;

    always_comb begin
        r_d        = r_q;
        r_d.start  = 1'b0;
        r_d.to_hit = 1'b0;
        r_d.rep_v  = 1'b0;
        tmr_load   = 1'b0;
        tmr_run    = 1'b0;
        fifo_wr    = 1'b0;
        fifo_data  = '0;

        case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    case (cmd)
                        CMD_CONFIGURE: begin
                            r_d.state    = ST_CFG;
                            r_d.cfg_cnt  = '0;
                            r_d.cfg_addr = in_addr;
                            r_d.cfg_tmo  = in_word[TMO_W-1:0];
                        end
                        CMD_HEADER: begin
                            if (r_q.lock_on && (in_addr == r_q.lock_addr)) begin
                                r_d.start      = 1'b1;
                                r_d.len        = hdr_len;
                                r_d.rem        = hdr_words;
                                r_d.tail_lanes = hdr_len[LANE_W-1:0];
                                tmr_load       = 1'b1;
                                if (hdr_words != '0) r_d.state = ST_DATA;
                            end
                        end
                        CMD_RELEASE: begin
                            if (r_q.lock_on && (in_addr == r_q.lock_addr)) begin
                                r_d.lock_on = 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end

            ST_CFG: begin
                if (accept) begin
                    r_d.cfg_cnt = r_q.cfg_cnt + 1'b1;
                    case (r_q.cfg_cnt)
                        2'd0: r_d.cfg_ip    = in_word;
                        2'd1: r_d.cfg_ports = in_word;
                        default: begin
                            r_d.state    = ST_IDLE;
                            r_d.rep_v    = 1'b1;
                            r_d.rep_ack  = grant;
                            r_d.rep_addr = in_word[ADDR_W-1:0];
                            if (grant) begin
                                r_d.lock_on   = 1'b1;
                                r_d.lock_addr = r_q.cfg_addr;
                                r_d.tmo       = r_q.cfg_tmo;
                                r_d.ip        = r_q.cfg_ip;
                                r_d.ports     = r_q.cfg_ports;
                            end
                        end
                    endcase
                end
            end

            ST_DATA: begin
                if (accept) begin
                    fifo_wr   = 1'b1;
                    fifo_data = (r_q.rem == WCNT_W'(1)) ? masked_word : in_word;
                    r_d.rem   = r_q.rem - 1'b1;
                    tmr_load  = 1'b1;
                    if (r_q.rem == WCNT_W'(1)) r_d.state = ST_IDLE;
                end else if (tmr_expired) begin
                    r_d.state  = ST_PAD;
                    r_d.to_hit = 1'b1;
                end else begin
                    tmr_run = 1'b1;
                end
            end

            default: begin
                if (!fifo_full) begin
                    fifo_wr = 1'b1;
                    r_d.rem = r_q.rem - 1'b1;
                    if (r_q.rem == WCNT_W'(1)) r_d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign in_ready    = ready_c;
    assign pkt_start   = r_q.start;
    assign pkt_len     = r_q.len;
    assign dst_ip      = r_q.ip;
    assign dst_port    = r_q.ports[31:16];
    assign src_port    = r_q.ports[15:0];
    assign locked      = r_q.lock_on;
    assign timeout_hit = r_q.to_hit;
    assign rep_valid   = r_q.rep_v;
    assign rep_word    = r_q.rep_v ? reply_word(r_q.rep_ack) : '0;
    assign rep_dest    = r_q.rep_addr;
endmodule

// File: rtl/txl_lock_checker.sv
module txl_lock_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        fifo_full,
    input logic        fifo_wr,
    input logic [31:0] fifo_data,
    input logic        pkt_start,
    input logic        locked,
    input logic        timeout_hit,
    input logic        rep_valid,
    input logic [31:0] rep_word
);
    assert_no_write_when_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !fifo_full);

    assert_reply_format_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> ((rep_word[31:28] == 4'h5) || (rep_word[31:28] == 4'h6))
                      && rep_word[27] && (rep_word[26:0] == 27'd0));

    assert_ack_holds_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && (rep_word[31:28] == 4'h5)) |-> locked);

    assert_lock_only_by_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (rep_valid && (rep_word[31:28] == 4'h5)));

    assert_start_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |-> locked);

    assert_write_needs_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> locked);

    assert_pad_begins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_hit |-> (fifo_wr || fifo_full) && !in_ready);

    assert_nonzero_from_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && (fifo_data != 32'd0)) |-> (in_valid && in_ready));
endmodule

bind tx_cmd_lock txl_lock_checker u_txl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .fifo_full   (fifo_full),
    .fifo_wr     (fifo_wr),
    .fifo_data   (fifo_data),
    .pkt_start   (pkt_start),
    .locked      (locked),
    .timeout_hit (timeout_hit),
    .rep_valid   (rep_valid),
    .rep_word    (rep_word)
);

// File: tb/test_tx_cmd_lock.sv
module test_tx_cmd_lock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic [31:0] in_addr = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr;
    logic [31:0] fifo_data;
    logic        pkt_start;
    logic [10:0] pkt_len;
    logic [31:0] dst_ip;
    logic [15:0] dst_port, src_port;
    logic        locked, timeout_hit, rep_valid;
    logic [31:0] rep_word, rep_dest;

    int total = 0, bad = 0;
    int rep_cnt = 0, start_cnt = 0, to_cnt = 0, wr_cnt = 0;
    logic [31:0] last_rep, last_dest;
    logic [31:0] fq [0:63];

    localparam logic [31:0] ADDR_A = 32'h0123_4567;
    localparam logic [31:0] ADDR_B = 32'h0123_4568;
    localparam logic [31:0] SEND_1 = 32'h0000_0A10;
    localparam logic [31:0] SEND_2 = 32'h0000_0B20;

    always #5 clk = ~clk;

    tx_cmd_lock i_tx_cmd_lock (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_addr(in_addr), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .pkt_start(pkt_start),
        .pkt_len(pkt_len), .dst_ip(dst_ip), .dst_port(dst_port),
        .src_port(src_port), .locked(locked), .timeout_hit(timeout_hit),
        .rep_valid(rep_valid), .rep_word(rep_word), .rep_dest(rep_dest)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (rep_valid) begin
                rep_cnt++;
                last_rep  = rep_word;
                last_dest = rep_dest;
            end
            if (pkt_start) start_cnt++;
            if (timeout_hit) to_cnt++;
            if (fifo_wr) begin
                fq[wr_cnt[5:0]] = fifo_data;
                wr_cnt++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] addr, input logic [31:0] word);
        in_valid = 1'b1;
        in_addr  = addr;
        in_word  = word;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic configure(input logic [31:0] addr, input logic [27:0] tmo,
                             input logic [31:0] ip, input logic [31:0] ports,
                             input logic [31:0] sender);
        put(addr, {4'h0, tmo});
        put(addr, ip);
        put(addr, ports);
        put(addr, sender);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R11 locked", {31'd0, locked}, 32'd0);
        check("R11 in_ready", {31'd0, in_ready}, 32'd1);
        check("R11 rep_valid", {31'd0, rep_valid}, 32'd0);
        check("R11 fifo_wr", {31'd0, fifo_wr}, 32'd0);
    endtask

    task automatic t_unlocked_drops;
        int r0 = rep_cnt, w0 = wr_cnt;
        put(ADDR_A, 32'h7000_0001);
        put(ADDR_A, {4'h1, 11'd8, 17'd0});
        put(ADDR_A, 32'h1111_2222);
        repeat (2) @(negedge clk);
        check("R1 unknown type no reply", rep_cnt, r0);
        check("R6 header unlocked no start", start_cnt, 0);
        check("R1 R6 no fifo write", wr_cnt, w0);
        check("R1 still unlocked", {31'd0, locked}, 32'd0);
    endtask

    task automatic t_grant;
        configure(ADDR_A, 28'd50, 32'hC0A8_0102, 32'h1F90_0BB8, SEND_1);
        check("R2 ack word", last_rep, 32'h5800_0000);
        check("R2 ack dest", last_dest, SEND_1);
        check("R2 reply count", rep_cnt, 1);
        check("R2 dst_ip", dst_ip, 32'hC0A8_0102);
        check("R2 ports", {dst_port, src_port}, 32'h1F90_0BB8);
        check("R3 locked", {31'd0, locked}, 32'd1);
        put(SEND_1, {4'h1, 11'd4, 17'd0});
        repeat (2) @(negedge clk);
        check("R3 header at sender addr dropped", start_cnt, 0);
    endtask

    task automatic t_refuse;
        configure(ADDR_B, 28'd9, 32'hDEAD_BEEF, 32'h0001_0002, SEND_2);
        check("R4 nack word", last_rep, 32'h6800_0000);
        check("R4 nack dest", last_dest, SEND_2);
        check("R4 ip unchanged", dst_ip, 32'hC0A8_0102);
        check("R4 still locked", {31'd0, locked}, 32'd1);
        put(ADDR_B, {4'h1, 11'd4, 17'd0});
        repeat (2) @(negedge clk);
        check("R6 header other addr dropped", start_cnt, 0);
    endtask

    task automatic t_packet;
        int w0 = wr_cnt;
        put(ADDR_A, {4'h1, 11'd10, 17'h1ABCD});
        check("R5 pkt_start pulse", {31'd0, pkt_start}, 32'd1);
        check("R5 pkt_len", {21'd0, pkt_len}, 32'd10);
        in_valid = 1'b1; in_addr = ADDR_B; in_word = 32'h0000_0000;
        #1;
        check("R8 other addr held off", {31'd0, in_ready}, 32'd0);
        in_addr = ADDR_A; fifo_full = 1'b1;
        #1;
        check("R8 full holds off", {31'd0, in_ready}, 32'd0);
        check("R12 no write when full", {31'd0, fifo_wr}, 32'd0);
        @(negedge clk);
        fifo_full = 1'b0; in_valid = 1'b0;
        put(ADDR_A, 32'h4433_2211);
        put(ADDR_A, 32'h8877_6655);
        put(ADDR_A, 32'hAABB_CCDD);
        @(negedge clk);
        check("R7 word count", wr_cnt - w0, 3);
        check("R7 first word", fq[w0[5:0]], 32'h4433_2211);
        check("R7 tail masked", fq[w0[5:0] + 6'd2], 32'h0000_CCDD);
        check("R7 back to idle", {31'd0, in_ready}, 32'd1);
        put(ADDR_A, {4'h1, 11'd0, 17'd0});
        repeat (2) @(negedge clk);
        check("R5 zero length start", start_cnt, 2);
        check("R5 zero length no write", wr_cnt - w0, 3);
    endtask

    task automatic t_timeout;
        int w0 = wr_cnt, r0 = rep_cnt;
        configure(ADDR_A, 28'd6, 32'h0A00_0001, 32'h0050_0051, SEND_1);
        check("R2 re-grant same addr", last_rep, 32'h5800_0000);
        check("R2 reply one more", rep_cnt, r0 + 1);
        put(ADDR_A, {4'h1, 11'd16, 17'd0});
        put(ADDR_A, 32'h1234_5678);
        repeat (6) @(negedge clk);
        put(ADDR_A, 32'h9ABC_DEF0);
        check("R9 no timeout within T", to_cnt, 0);
        repeat (20) @(negedge clk);
        check("R9 timeout pulse", to_cnt, 1);
        check("R9 total writes", wr_cnt - w0, 4);
        check("R9 pad zero 1", fq[w0[5:0] + 6'd2], 32'd0);
        check("R9 pad zero 2", fq[w0[5:0] + 6'd3], 32'd0);
        check("R9 lock kept", {31'd0, locked}, 32'd1);
        check("R9 ready again", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_release;
        int r0 = rep_cnt;
        put(ADDR_B, 32'h2000_0000);
        @(negedge clk);
        check("R10 release other addr ignored", {31'd0, locked}, 32'd1);
        put(ADDR_A, 32'h2FFF_FFFF);
        check("R10 unlocked", {31'd0, locked}, 32'd0);
        @(negedge clk);
        check("R10 no reply", rep_cnt, r0);
        configure(ADDR_B, 28'd5, 32'h0B0B_0B0B, 32'h0007_0008, SEND_2);
        check("R3 new owner ack", last_rep, 32'h5800_0000);
        check("R3 new ip", dst_ip, 32'h0B0B_0B0B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unlocked_drops();
        t_grant();
        t_refuse();
        t_packet();
        t_timeout();
        t_release();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule